// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer for a chip that runs its control logic from one system clock but times the watchdog from a slow free-running oscillator. Each edge of the slow oscillator arrives as a one-cycle strobe on `osc_tick`. A power-of-two prescaler turns those strobes into divided ticks. A 16-bit counter advances on each divided tick. When the counter matches a programmable limit, the block emits a one-cycle pulse on `wdt_pulse` and starts counting again from zero.

Software programs the block through a small byte-wide register port. One control byte holds the 3-bit rate field, the watchdog enable and the oscillator enable. Two more bytes hold the low and high halves of the limit. The rate field and the limit are frozen while the watchdog is enabled. The enable bits themselves stay writable. A `kick` strobe from the supervised logic clears the counter, so firmware that keeps kicking in time never sees a pulse.

Top module: `wdt_prescaled`

## Requirements
- R1: After reset, every register reads 0x00 and `wdt_pulse` is low. The watchdog and the oscillator gate both start disabled.
- R2: Register address 0 is the control byte: bits 2:0 are the rate, bit 3 is the watchdog enable, bit 4 is the oscillator enable, and bits 7:5 read as 0. Address 1 holds the limit bits 7:0 and address 2 holds the limit bits 15:8. Address 3 always reads 0, and writes to it have no effect.
- R3: While both enables are 1, a divided tick occurs on every 2^rate-th `osc_tick` strobe, so the ratio ranges from 1 up to 128. The first divided tick comes on the 2^rate-th strobe after the point where both enables became 1.
- R4: A divided tick that finds the counter equal to the limit causes a pulse on `wdt_pulse` in the next cycle. That pulse is exactly one system clock wide, and the counter restarts from 0. With a limit of N, a pulse therefore follows every N+1 divided ticks.
- R5: While the watchdog enable is 0, no pulse is produced and the counter holds its value. The prescaler restarts from zero.
- R6: While the oscillator enable is 0, `osc_tick` is ignored. No divided ticks occur, no pulse is produced, and the prescaler restarts from zero.
- R7: A write to the rate field or to either limit byte is ignored if the watchdog enable was 1 before that write. Writes to the two enable bits always take effect.
- R8: A `kick` sets the counter to 0 and produces no pulse. This holds even when the kick arrives in the same cycle as the divided tick that would have matched the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle strobe per slow oscillator edge |
| kick | input | 1 | Clears the watchdog counter |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| wdt_pulse | output | 1 | One-cycle watchdog expiry pulse |

## Verification
The assertions check the following on every cycle:
- a pulse appears only after a cycle with the watchdog enabled and an oscillator strobe that was let through;
- the counter stays frozen while the watchdog is off;
- the rate and the limit never change during a cycle that follows an enabled cycle;
- a kick always leaves the counter at zero with no pulse.

The exact pulse spacing for each prescale ratio and limit, the restart after a match, the read-back of blocked writes, and the handling of a kick that coincides with a match can only be shown by the bench scenarios. The bench compares each pulse against a cycle-exact schedule.

// File: rtl/wdt_prescaled.sv
module wdt_prescaled #(
  parameter int RATE_W = 3,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              kick,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              wdt_pulse
);

  localparam int PRE_W  = (1 << RATE_W) - 1;
  localparam int HI_W   = CNT_W - DATA_W;
  localparam int EN_BIT = RATE_W;
  localparam int OS_BIT = RATE_W + 1;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(2);
  localparam logic [PRE_W-1:0]  ONES   = '1;

  logic [RATE_W-1:0] rate_q;
  logic              en_q, osc_q;
  logic [CNT_W-1:0]  lim_q, cnt_q;
  logic [PRE_W-1:0]  pre_q, pre_mask;
  logic              pulse_q;

  wire run      = en_q & osc_q;
  wire wr_ctrl  = reg_we & (reg_addr == A_CTRL);
  wire wr_lo    = reg_we & (reg_addr == A_LO) & ~en_q;
  wire wr_hi    = reg_we & (reg_addr == A_HI) & ~en_q;

  assign pre_mask = ONES >> (PRE_W - int'(rate_q));
  wire div_tick = run & osc_tick & (pre_q == pre_mask);
  wire hit      = div_tick & (cnt_q == lim_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q <= '0;
      en_q   <= 1'b0;
      osc_q  <= 1'b0;
    end else if (wr_ctrl) begin
      en_q  <= reg_wdata[EN_BIT];
      osc_q <= reg_wdata[OS_BIT];
      if (!en_q) rate_q <= reg_wdata[RATE_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lim_q <= '0;
    else begin
      if (wr_lo) lim_q[DATA_W-1:0]     <= reg_wdata;
      if (wr_hi) lim_q[CNT_W-1:DATA_W] <= reg_wdata[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run)   pre_q <= '0;
    else if (osc_tick)    pre_q <= div_tick ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (kick || hit) cnt_q <= '0;
    else if (div_tick)    cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= hit & ~kick;
  end

  assign wdt_pulse = pulse_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[RATE_W-1:0] = rate_q;
        reg_rdata[EN_BIT]     = en_q;
        reg_rdata[OS_BIT]     = osc_q;
      end
      A_LO:    reg_rdata = lim_q[DATA_W-1:0];
      A_HI:    reg_rdata[HI_W-1:0] = lim_q[CNT_W-1:DATA_W];
      default: reg_rdata = '0;
    endcase
  end

  p_pulse_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_pulse |-> $past(en_q));
  p_pulse_needs_osc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_pulse |-> $past(osc_q && osc_tick));
  p_hold_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !kick) |=> $stable(cnt_q));
  p_lim_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(lim_q));
  p_rate_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(rate_q));
  p_kick_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt_q == '0 && !wdt_pulse));
  p_pre_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_q |=> (pre_q == '0));

endmodule

// File: tb/sim_wdt_prescaled.sv
module sim_wdt_prescaled;
  logic       clk = 1'b0, rst_n = 1'b0, osc_tick = 1'b0, kick = 1'b0, reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       wdt_pulse;

  wdt_prescaled u0 (.clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .kick(kick),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .wdt_pulse(wdt_pulse));

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  int exp_q[$];
  int m_rate = 0, m_en = 0, m_osc = 0, m_lim = 0, m_pre = 0, m_cnt = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic model_edge(bit o, bit k);
    bit tick = 0;
    if (!(m_en && m_osc)) m_pre = 0;
    else if (o) begin
      if (m_pre == (1 << m_rate) - 1) begin m_pre = 0; tick = 1; end
      else m_pre++;
    end
    if (k) m_cnt = 0;
    else if (tick) begin
      if (m_cnt == m_lim) begin m_cnt = 0; exp_q.push_back(cyc + 1); end
      else m_cnt++;
    end
  endtask

  task automatic step(bit o, bit k);
    @(negedge clk);
    reg_we = 0; osc_tick = o; kick = k;
    model_edge(o, k);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_we = 1; reg_addr = 2'(a); reg_wdata = 8'(d); osc_tick = 0; kick = 0;
    model_edge(0, 0);
    case (a)
      0: begin
        if (!m_en) m_rate = d & 7;
        m_en = (d >> 3) & 1;
        m_osc = (d >> 4) & 1;
      end
      1: if (!m_en) m_lim = (m_lim & 'hFF00) | (d & 'hFF);
      2: if (!m_en) m_lim = (m_lim & 'hFF) | ((d & 'hFF) << 8);
      default: ;
    endcase
  endtask

  task automatic rd(int a, int e, string req);
    @(negedge clk);
    reg_we = 0; reg_addr = 2'(a); osc_tick = 0; kick = 0;
    model_edge(0, 0);
    #1;
    chk(reg_rdata == 8'(e), req, reg_rdata, e);
  endtask

  // osc strobe every osc_gap cycles; kick every kick_gap cycles (0 = none)
  task automatic run(int n, int osc_gap, int kick_gap);
    for (int i = 0; i < n; i++)
      step((i % osc_gap) == 0, kick_gap != 0 && (i % kick_gap) == kick_gap - 1);
  endtask

  // monitor: compares pulses against the scheduled cycles (R4 timing)
  always @(posedge clk) begin
    #3;
    while (exp_q.size() > 0 && exp_q[0] < cyc) begin
      chk(0, "R4 missed pulse", 0, exp_q[0]);
      void'(exp_q.pop_front());
    end
    if (wdt_pulse) begin
      if (exp_q.size() > 0 && exp_q[0] == cyc) begin
        chk(1, "R4", 1, 1);
        void'(exp_q.pop_front());
      end else chk(0, "R4 unexpected pulse", 1, 0);
    end else if (exp_q.size() > 0 && exp_q[0] == cyc) begin
      chk(0, "R4 pulse absent", 0, 1);
      void'(exp_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog timeout", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, 'h00, "R1"); rd(1, 'h00, "R1"); rd(2, 'h00, "R1");
    chk(wdt_pulse == 0, "R1 pulse", wdt_pulse, 0);
    // R2 register map
    wr(1, 3); wr(2, 0); wr(0, 'hF0);
    rd(0, 'h10, "R2"); rd(1, 3, "R2"); rd(2, 0, "R2");
    wr(3, 'hFF); rd(3, 0, "R2");
    // R3 R4 ratio 1, limit 3
    wr(0, 'h18); run(20, 1, 0);
    // R5 disabled: no pulses, count held
    wr(0, 'h10); run(12, 1, 0);
    wr(0, 'h12); wr(1, 1); wr(0, 'h1A); rd(0, 'h1A, "R3");
    run(40, 2, 0);
    // R7 lock while enabled
    wr(1, 'h55); wr(2, 7); wr(0, 'h1D);
    rd(0, 'h1A, "R7"); rd(1, 1, "R7"); rd(2, 0, "R7");
    run(30, 1, 0);
    // R8 kicks, some on a matching tick
    run(60, 1, 7);
    run(40, 1, 6);
    // R6 oscillator gate off
    wr(0, 'h0F); rd(0, 'h0A, "R6"); run(30, 1, 0);
    wr(0, 'h1A); run(20, 1, 0);
    // R3 ratio 128, limit 0
    wr(0, 'h10); wr(0, 'h17); wr(1, 0); wr(2, 0); wr(0, 'h1F);
    rd(0, 'h1F, "R3"); run(300, 1, 0);
    // R2 high byte: limit 0x0102 at ratio 1
    wr(0, 'h10); wr(0, 'h10); wr(1, 2); wr(2, 1); wr(0, 'h18);
    rd(2, 1, "R2"); rd(1, 2, "R2");
    run(600, 1, 0);
    run(3, 1, 0);
    chk(exp_q.size() == 0, "R4 pending pulses", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule